// File: doc/BRIEF.md
# Accumulator Rotate Unit

This block executes the four one-byte accumulator rotate operations of an 8-bit processor: circular left, circular right, left through carry and right through carry. Each clock it samples an opcode, the accumulator and the flag register. One clock later it presents the rotated accumulator, the updated flag register, the number of processor cycles the operation costs, and a valid bit that says whether the opcode was one of the four.

The unit touches only three flags. Carry receives the bit shifted out, and half-carry and subtract are cleared. Sign, zero, parity/overflow and the two copy bits keep their input values, so a rotate that produces zero does not set the zero flag. An opcode outside the four leaves valid low, reports a cycle cost of zero and returns the accumulator and flags unchanged. The execute stage can therefore merge the outputs without a separate bypass mux.

Top module: `acc_rotate_unit`

## Requirements
- R1: Opcode 0x07 (circular left) gives acc_o = {acc[6:0], acc[7]} and puts acc[7] into carry (flag bit 0).
- R2: Opcode 0x0F (circular right) gives acc_o = {acc[0], acc[7:1]} and puts acc[0] into carry.
- R3: Opcode 0x17 (left through carry) gives acc_o = {acc[6:0], old carry} and puts acc[7] into carry.
- R4: Opcode 0x1F (right through carry) gives acc_o = {old carry, acc[7:1]} and puts acc[0] into carry.
- R5: For all four rotate opcodes, half-carry (flag bit 4) and subtract (flag bit 1) are cleared.
- R6: For all four rotate opcodes, flag bits 2, 3, 5, 6 and 7 (mask 0xEC) equal their input values, including when the result is zero.
- R7: cycles_o is 4 when valid_o is high and 0 when valid_o is low.
- R8: For any other opcode, valid_o is low and acc_o and flags_o equal the sampled acc_i and flags_i.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge, and a new opcode is accepted on every cycle.
- R10: While rst_n is low, acc_o, flags_o and cycles_o are zero and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 8 | Instruction byte |
| acc_i | input | 8 | Accumulator before the operation |
| flags_i | input | 8 | Flag register before the operation |
| acc_o | output | 8 | Accumulator after the operation |
| flags_o | output | 8 | Flag register after the operation |
| cycles_o | output | 4 | Processor cycle cost, zero for an unrecognised opcode |
| valid_o | output | 1 | High when the sampled opcode was a rotate |

## Verification
The assertions are checked on every cycle after reset. They cover the data movement of each of the four rotates against the previous cycle's inputs, the clearing of half-carry and subtract, the preservation of the untouched flag mask, the pairing of cycle cost with valid, and pass-through for unknown opcodes. Two things can only be shown by the bench's scenarios. One is the reset state, since the sampled outputs before the first edge are undefined. The other is the behaviour of particular data patterns: a zero result that leaves the zero flag clear, carry chaining with both values of the old carry, a full sweep of accumulator values, and back-to-back opcodes that change on every cycle.

// File: rtl/acc_rotate_pkg.sv
package acc_rotate_pkg;

    localparam int unsigned ROT_W = 8;

    localparam int unsigned FLG_CARRY = 0;
    localparam int unsigned FLG_SUB   = 1;
    localparam int unsigned FLG_PV    = 2;
    localparam int unsigned FLG_CPY3  = 3;
    localparam int unsigned FLG_HALF  = 4;
    localparam int unsigned FLG_CPY5  = 5;
    localparam int unsigned FLG_ZERO  = 6;
    localparam int unsigned FLG_SIGN  = 7;

    localparam logic [7:0] OPC_RLC = 8'h07;
    localparam logic [7:0] OPC_RRC = 8'h0F;
    localparam logic [7:0] OPC_RL  = 8'h17;
    localparam logic [7:0] OPC_RR  = 8'h1F;

    typedef enum logic [2:0] {
        ROT_NONE = 3'd0,
        ROT_RLC  = 3'd1,
        ROT_RRC  = 3'd2,
        ROT_RL   = 3'd3,
        ROT_RR   = 3'd4
    } rot_op_e;

    typedef struct packed {
        logic [ROT_W-1:0] acc;
        logic [ROT_W-1:0] flags;
        logic [3:0]       cycles;
        logic             valid;
    } rot_out_t;

endpackage

// File: rtl/acc_rotate_decode.sv
module acc_rotate_decode
    import acc_rotate_pkg::*;
(
    input  logic [7:0] opcode,
    output rot_op_e    op
);
    always_comb begin
        case (opcode)
            OPC_RLC: op = ROT_RLC;
            OPC_RRC: op = ROT_RRC;
            OPC_RL:  op = ROT_RL;
            OPC_RR:  op = ROT_RR;
            default: op = ROT_NONE;
        endcase
    end
endmodule

// File: rtl/acc_rotate_shift.sv
module acc_rotate_shift
    import acc_rotate_pkg::*;
#(
    parameter int unsigned W = ROT_W
) (
    input  rot_op_e      op,
    input  logic [W-1:0] acc_in,
    input  logic         carry_in,
    output logic [W-1:0] acc_out,
    output logic         carry_out
);
    localparam int unsigned MSB = W - 1;

    logic fill_left;
    logic fill_right;

    // Bit that enters the vacated end: the wrapped bit for circular
    // forms, the previous carry for the through-carry forms.
    assign fill_left  = (op == ROT_RL) ? carry_in : acc_in[MSB];
    assign fill_right = (op == ROT_RR) ? carry_in : acc_in[0];

    always_comb begin
        acc_out   = acc_in;
        carry_out = carry_in;
        case (op)
            ROT_RLC, ROT_RL: begin
                acc_out   = {acc_in[MSB-1:0], fill_left};
                carry_out = acc_in[MSB];
            end
            ROT_RRC, ROT_RR: begin
                acc_out   = {fill_right, acc_in[MSB:1]};
                carry_out = acc_in[0];
            end
            default: begin
                acc_out   = acc_in;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/acc_rotate_flags.sv
module acc_rotate_flags
    import acc_rotate_pkg::*;
#(
    parameter int unsigned W = ROT_W
) (
    input  logic         active,
    input  logic         carry_new,
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] flags_out
);
    // Per-bit merge: carry takes the shifted-out bit, half-carry and
    // subtract are forced low, the rest pass through.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == FLG_CARRY) begin : g_carry
            assign flags_out[b] = active ? carry_new : flags_in[b];
        end else if (b == FLG_HALF || b == FLG_SUB) begin : g_clear
            assign flags_out[b] = active ? 1'b0 : flags_in[b];
        end else begin : g_keep
            assign flags_out[b] = flags_in[b];
        end
    end
endmodule

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit
    import acc_rotate_pkg::*;
#(
    parameter int unsigned ROT_CYCLES = 4,
    parameter int unsigned CYC_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       opcode_i,
    input  logic [ROT_W-1:0] acc_i,
    input  logic [ROT_W-1:0] flags_i,
    output logic [ROT_W-1:0] acc_o,
    output logic [ROT_W-1:0] flags_o,
    output logic [CYC_W-1:0] cycles_o,
    output logic             valid_o
);
    localparam logic [CYC_W-1:0] COST = CYC_W'(ROT_CYCLES);

    rot_op_e          op;
    logic             is_rot;
    logic [ROT_W-1:0] acc_rot;
    logic             carry_rot;
    logic [ROT_W-1:0] flags_mrg;

    rot_out_t out_d;
    rot_out_t out_q;

    acc_rotate_decode u_dec (
        .opcode (opcode_i),
        .op     (op)
    );

    assign is_rot = (op != ROT_NONE);

    acc_rotate_shift #(.W(ROT_W)) u_shift (
        .op        (op),
        .acc_in    (acc_i),
        .carry_in  (flags_i[FLG_CARRY]),
        .acc_out   (acc_rot),
        .carry_out (carry_rot)
    );

    acc_rotate_flags #(.W(ROT_W)) u_flags (
        .active    (is_rot),
        .carry_new (carry_rot),
        .flags_in  (flags_i),
        .flags_out (flags_mrg)
    );

    always_comb begin
        out_d.acc    = acc_rot;
        out_d.flags  = flags_mrg;
        out_d.cycles = is_rot ? COST : '0;
        out_d.valid  = is_rot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign acc_o    = out_q.acc;
    assign flags_o  = out_q.flags;
    assign cycles_o = out_q.cycles[CYC_W-1:0];
    assign valid_o  = out_q.valid;
endmodule

// File: rtl/acc_rotate_unit_chk.sv
module acc_rotate_unit_chk
    import acc_rotate_pkg::*;
#(
    parameter int unsigned ROT_CYCLES = 4,
    parameter int unsigned CYC_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       opcode_i,
    input logic [ROT_W-1:0] acc_i,
    input logic [ROT_W-1:0] flags_i,
    input logic [ROT_W-1:0] acc_o,
    input logic [ROT_W-1:0] flags_o,
    input logic [CYC_W-1:0] cycles_o,
    input logic             valid_o
);
    localparam logic [ROT_W-1:0] KEEP = 8'hEC;

    // Armed one edge after reset release so $past refers to a captured input.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r1_rlc: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode_i) == OPC_RLC) |->
            (acc_o == {$past(acc_i[6:0]), $past(acc_i[7])}) && (flags_o[FLG_CARRY] == $past(acc_i[7])));

    a_r2_rrc: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode_i) == OPC_RRC) |->
            (acc_o == {$past(acc_i[0]), $past(acc_i[7:1])}) && (flags_o[FLG_CARRY] == $past(acc_i[0])));

    a_r3_rl: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode_i) == OPC_RL) |->
            (acc_o == {$past(acc_i[6:0]), $past(flags_i[0])}) && (flags_o[FLG_CARRY] == $past(acc_i[7])));

    a_r4_rr: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode_i) == OPC_RR) |->
            (acc_o == {$past(flags_i[0]), $past(acc_i[7:1])}) && (flags_o[FLG_CARRY] == $past(acc_i[0])));

    a_r5_hn_clear: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!flags_o[FLG_HALF] && !flags_o[FLG_SUB]));

    a_r6_keep_mask: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        valid_o |-> ((flags_o & KEEP) == ($past(flags_i) & KEEP)));

    a_r7_cost: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cycles_o == CYC_W'(ROT_CYCLES)));

    a_r7_cost_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (cycles_o == '0));

    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !valid_o |-> ((acc_o == $past(acc_i)) && (flags_o == $past(flags_i))));

    a_r9_valid_track: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        valid_o == (($past(opcode_i) == OPC_RLC) || ($past(opcode_i) == OPC_RRC) ||
                    ($past(opcode_i) == OPC_RL)  || ($past(opcode_i) == OPC_RR)));
endmodule

bind acc_rotate_unit acc_rotate_unit_chk #(
    .ROT_CYCLES (ROT_CYCLES),
    .CYC_W      (CYC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (opcode_i),
    .acc_i    (acc_i),
    .flags_i  (flags_i),
    .acc_o    (acc_o),
    .flags_o  (flags_o),
    .cycles_o (cycles_o),
    .valid_o  (valid_o)
);

// File: tb/acc_rotate_unit_test.sv
module acc_rotate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {opcode, acc, flags, exp_acc, exp_flags, exp_valid}
    localparam logic [40:0] VEC [NVEC] = '{
        {8'h07, 8'h81, 8'h00, 8'h03, 8'h01, 1'b1}, // R1
        {8'h07, 8'h40, 8'hFF, 8'h80, 8'hEC, 1'b1}, // R1 R5 R6
        {8'h0F, 8'h01, 8'h00, 8'h80, 8'h01, 1'b1}, // R2
        {8'h0F, 8'h02, 8'h13, 8'h01, 8'h00, 1'b1}, // R2 R5
        {8'h17, 8'h80, 8'h00, 8'h00, 8'h01, 1'b1}, // R3 R6 zero result, zero flag untouched
        {8'h17, 8'h55, 8'h01, 8'hAB, 8'h00, 1'b1}, // R3 old carry in
        {8'h1F, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1}, // R4
        {8'h1F, 8'hAA, 8'hED, 8'hD5, 8'hEC, 1'b1}, // R4 R6
        {8'h00, 8'h3C, 8'h5A, 8'h3C, 8'h5A, 1'b0}, // R8
        {8'h08, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0}, // R8
        {8'h27, 8'h99, 8'h12, 8'h99, 8'h12, 1'b0}, // R8
        {8'h1F, 8'hFF, 8'h00, 8'h7F, 8'h01, 1'b1}  // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] flags_i = 8'h00;
    logic [7:0] acc_o;
    logic [7:0] flags_o;
    logic [3:0] cycles_o;
    logic       valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_rotate_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode_i),
        .acc_i    (acc_i),
        .flags_i  (flags_i),
        .acc_o    (acc_o),
        .flags_o  (flags_o),
        .cycles_o (cycles_o),
        .valid_o  (valid_o)
    );

    task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef,
                         input logic ev);
        logic [3:0] ec;
        ec = ev ? 4'd4 : 4'd0;
        checks++;
        if (acc_o !== ea || flags_o !== ef || valid_o !== ev || cycles_o !== ec) begin
            fails++;
            $display("FAIL %s: acc=%h flags=%h valid=%b cyc=%0d expected acc=%h flags=%h valid=%b cyc=%0d",
                     req, acc_o, flags_o, valid_o, cycles_o, ea, ef, ev, ec);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f);
        @(negedge clk);
        opcode_i = op;
        acc_i    = a;
        flags_i  = f;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ea;
        logic [7:0] ef;

        // R10: reset state
        apply(8'h07, 8'hFF, 8'hFF);
        @(negedge clk);
        check("R10 reset", 8'h00, 8'h00, 1'b0);
        rst_n = 1'b1;

        // Table walk (R1-style tags per entry in the table comments)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
            @(negedge clk);
            check($sformatf("R1..R8 vector %0d", i), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
        end

        // R9: back-to-back opcodes, one result per cycle
        @(negedge clk);
        opcode_i = 8'h07; acc_i = 8'h01; flags_i = 8'h00;
        @(negedge clk);
        check("R9 b2b first", 8'h02, 8'h00, 1'b1);
        opcode_i = 8'h0F; acc_i = 8'h01; flags_i = 8'h10;
        @(negedge clk);
        check("R9 b2b second", 8'h80, 8'h01, 1'b1);
        opcode_i = 8'hCB; acc_i = 8'h77; flags_i = 8'h44;
        @(negedge clk);
        check("R9 b2b third R8", 8'h77, 8'h44, 1'b0);

        // R1 R3 R6 sweep: every accumulator value, alternating carry
        for (int a = 0; a < 256; a++) begin
            logic [7:0] av;
            logic [7:0] fv;
            av = 8'(a);
            fv = (a[0]) ? 8'hFF : 8'h6C;
            apply(8'h17, av, fv);
            @(negedge clk);
            ea = {av[6:0], fv[0]};
            ef = (fv & 8'hEC) | {7'b0, av[7]};
            check("R3 sweep", ea, ef, 1'b1);
        end
        for (int a = 0; a < 256; a += 7) begin
            logic [7:0] av;
            av = 8'(a);
            apply(8'h0F, av, 8'hA6);
            @(negedge clk);
            ea = {av[0], av[7:1]};
            ef = 8'hA4 | {7'b0, av[0]};
            check("R2 sweep", ea, ef, 1'b1);
        end

        // R10: reset in mid-run clears the outputs
        apply(8'h1F, 8'hF0, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 mid-run reset", 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h07, 8'h80, 8'h00);
        @(negedge clk);
        check("R1 after reset", 8'h01, 8'h01, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule